// File: doc/BRIEF.md
# Bus-to-UDP transmit command bridge

This block sits between an on-chip bus port and the transmit side of a UDP stack. It reads 32-bit words from the bus receive port. Each word has an address-valid flag, and the port uses an empty / read-enable handshake. From those words it decodes two kinds of commands.

A transmit-configuration message loads the destination IP, the destination and source ports and the requester's reply address. The block then answers the requester over the bus write port, which has a full flag.

A transmit-data message carries a byte length and a payload. The block hands that payload to the UDP side as 16-bit half-words under a valid / read-enable handshake. While the transfer runs it holds a new-transmit flag together with the length and the stored addressing.

Everything runs on one clock. A data message that arrives before any configuration has been stored is read off the bus and thrown away.

Top module: `bus2udp_tx_bridge`

## Requirements
- R1: After reset, udp_new_tx, udp_valid and bus_tx_we are low and bus_rx_re is high.
- R2: A configuration message is five words, in this order:
  - an address word with bus_rx_av high;
  - a command word with opcode 0 in bits 31:28;
  - the destination IP;
  - a port word with the destination port in bits 31:16 and the source port in bits 15:0;
  - the reply address.
  Once the reply address is read, udp_dst_ip, udp_dst_port and udp_src_port show the stored values.
- R3: After a configuration, the block writes two words on the bus transmit port. The first is the stored reply address with bus_tx_av high. The second is 0x58000000 with bus_tx_av low.
- R4: While bus_tx_full is high, bus_tx_we stays high and bus_tx_data and bus_tx_av do not change. A word counts as delivered only in a cycle where bus_tx_we is high and bus_tx_full is low.
- R5: A data header has opcode 1 in bits 31:28 and the byte length in bits 27:17. udp_new_tx rises in the same cycle as udp_valid, and udp_len equals the header length.
- R6: A length of L bytes reads ceil(L/4) payload words and delivers ceil(L/2) half-words. Each payload word gives bits 15:0 first and bits 31:16 second.
- R7: A half-word is transferred only in a cycle where udp_valid and udp_re are both high. While udp_re is low, udp_valid and udp_data hold.
- R8: In the cycle after the last half-word is transferred, udp_new_tx and udp_valid are low and the block accepts a new message.
- R9: A data header received before any configuration is discarded together with its ceil(L/4) payload words. udp_new_tx does not rise and no reply is written.
- R10: bus_rx_re is low while a reply write is in progress. A bus word is taken only in a cycle where bus_rx_re is high and bus_rx_empty is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_rx_data | input | 32 | Incoming bus word |
| bus_rx_av | input | 1 | Incoming word is an address |
| bus_rx_empty | input | 1 | No incoming word available |
| bus_rx_re | output | 1 | Block takes the presented word |
| bus_tx_data | output | 32 | Reply word |
| bus_tx_av | output | 1 | Reply word is an address |
| bus_tx_we | output | 1 | Reply word offered |
| bus_tx_full | input | 1 | Reply port cannot accept |
| udp_new_tx | output | 1 | Transmit in progress |
| udp_len | output | 11 | Transmit byte length |
| udp_dst_ip | output | 32 | Destination IP |
| udp_dst_port | output | 16 | Destination port |
| udp_src_port | output | 16 | Source port |
| udp_data | output | 16 | Payload half-word |
| udp_valid | output | 1 | udp_data valid |
| udp_re | input | 1 | Consumer takes udp_data |

## Verification
The reply writer and the bus reader can both want the bus in the same stretch of time: the acknowledgement is still pending when the next message's address word is already waiting at the receive port. The bench holds bus_tx_full high across a whole configuration and queues one more word behind it. It then checks three things: the pending address word stays put, the queued word is not read, and after full drops the two reply words appear in order before the queued word is taken. The UDP handshake is also throttled by several read-enable patterns while payload words keep arriving, so that half-word ordering and word fetching overlap.

// File: rtl/b2u_pkg.sv
`timescale 1ns/1ps
package b2u_pkg;

   typedef enum logic [2:0] {
      P_IDLE, P_CMD, P_IP, P_PORTS, P_REPLY, P_ACK, P_PAY, P_SKIP
   } parse_e;

   typedef enum logic [1:0] {
      R_IDLE, R_ADDR, R_CODE
   } reply_e;

   localparam logic [3:0] OP_TXCFG  = 4'h0;
   localparam logic [3:0] OP_TXDATA = 4'h1;

endpackage

// File: rtl/b2u_reply.sv
`timescale 1ns/1ps
module b2u_reply
   import b2u_pkg::*;
#(
   parameter int                 DATA_W   = 32,
   parameter logic [DATA_W-1:0]  ACK_CODE = 32'h5800_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] addr,
   input  logic              full,
   output logic              we,
   output logic              av,
   output logic [DATA_W-1:0] data,
   output logic              busy
);

   reply_e            st;
   logic [DATA_W-1:0] addr_r;
   logic              accept;

   assign we     = (st != R_IDLE);
   assign av     = (st == R_ADDR);
   assign data   = (st == R_ADDR) ? addr_r : ACK_CODE;
   assign busy   = we;
   assign accept = we && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= R_IDLE;
         addr_r <= '0;
      end else begin
         case (st)
            R_IDLE: if (start) begin
               addr_r <= addr;
               st     <= R_ADDR;
            end
            R_ADDR: if (accept) st <= R_CODE;
            R_CODE: if (accept) st <= R_IDLE;
            default: st <= R_IDLE;
         endcase
      end
   end

   // R4: a stalled word is held unchanged
   a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      we && full |=> we && $stable(data) && $stable(av));

   // R3: the address word is followed by the code word
   a_r3_code_follows: assert property (@(posedge clk) disable iff (!rst_n)
      accept && av |=> we && !av);

endmodule

// File: rtl/b2u_unpack.sv
`timescale 1ns/1ps
module b2u_unpack #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int CNT_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  total,
   input  logic              load,
   input  logic [DATA_W-1:0] word_in,
   input  logic              re,
   output logic              need,
   output logic              valid,
   output logic [HALF_W-1:0] data,
   output logic              new_tx,
   output logic              done
);

   logic [CNT_W-1:0]  left;
   logic [DATA_W-1:0] hold;
   logic              hv;
   logic              hi;
   logic              fire;

   assign need  = (left != '0) && !hv;
   assign valid = hv;
   assign data  = hi ? hold[DATA_W-1:HALF_W] : hold[HALF_W-1:0];
   assign fire  = hv && re;
   assign done  = fire && (left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left   <= '0;
         hold   <= '0;
         hv     <= 1'b0;
         hi     <= 1'b0;
         new_tx <= 1'b0;
      end else begin
         if (start) begin
            left <= total;
            hi   <= 1'b0;
         end
         if (load) begin
            hold   <= word_in;
            hv     <= 1'b1;
            hi     <= 1'b0;
            new_tx <= 1'b1;
         end
         if (fire) begin
            left <= left - CNT_W'(1);
            if (!hi && left > CNT_W'(1)) hi <= 1'b1;
            else                         hv <= 1'b0;
            if (left == CNT_W'(1)) new_tx <= 1'b0;
         end
      end
   end

   // R7: without read-enable the half-word holds
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hv && !re |=> hv && $stable(data));

   // R5: the transmit flag rises together with valid data
   a_r5_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(new_tx) |-> hv);

   a_r5_valid_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      hv |-> new_tx);

   // R8: the last transfer closes the transmit
   a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !new_tx && !hv);

endmodule

// File: rtl/bus2udp_tx_bridge.sv
`timescale 1ns/1ps
module bus2udp_tx_bridge
   import b2u_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                HALF_W   = 16,
   parameter int                LEN_W    = 11,
   parameter int                OP_W     = 4,
   parameter logic [DATA_W-1:0] ACK_CODE = 32'h5800_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_rx_data,
   input  logic              bus_rx_av,
   input  logic              bus_rx_empty,
   output logic              bus_rx_re,
   output logic [DATA_W-1:0] bus_tx_data,
   output logic              bus_tx_av,
   output logic              bus_tx_we,
   input  logic              bus_tx_full,
   output logic              udp_new_tx,
   output logic [LEN_W-1:0]  udp_len,
   output logic [DATA_W-1:0] udp_dst_ip,
   output logic [HALF_W-1:0] udp_dst_port,
   output logic [HALF_W-1:0] udp_src_port,
   output logic [HALF_W-1:0] udp_data,
   output logic              udp_valid,
   input  logic              udp_re
);

   localparam int LEN_HI = DATA_W - OP_W - 1;
   localparam int LEN_LO = LEN_HI - LEN_W + 1;

   generate
      if (DATA_W != 2 * HALF_W) begin : g_bad_half
         $error("DATA_W must be twice HALF_W");
      end
      if (OP_W + LEN_W > DATA_W) begin : g_bad_hdr
         $error("opcode and length do not fit in a word");
      end
      if (OP_W != 4) begin : g_bad_op
         $error("opcode field must be 4 bits");
      end
   endgenerate

   parse_e            st;
   logic              cfg_ok;
   logic [DATA_W-1:0] ip_sh;
   logic [DATA_W-1:0] ports_sh;
   logic [LEN_W-1:0]  skip_left;

   logic              take;
   logic [OP_W-1:0]   hdr_op;
   logic [LEN_W-1:0]  hdr_len;
   logic [LEN_W:0]    len_ext;
   logic [LEN_W-1:0]  hdr_words;
   logic [LEN_W-1:0]  hdr_halves;
   logic              rep_start;
   logic              rep_busy;
   logic              up_start;
   logic              up_need;
   logic              up_done;

   assign hdr_op     = bus_rx_data[DATA_W-1 -: OP_W];
   assign hdr_len    = bus_rx_data[LEN_HI:LEN_LO];
   assign len_ext    = {1'b0, hdr_len};
   assign hdr_words  = LEN_W'((len_ext + (LEN_W+1)'(3)) >> 2);
   assign hdr_halves = LEN_W'((len_ext + (LEN_W+1)'(1)) >> 1);

   always_comb begin
      case (st)
         P_ACK:   bus_rx_re = 1'b0;
         P_PAY:   bus_rx_re = up_need;
         default: bus_rx_re = 1'b1;
      endcase
   end

   assign take      = bus_rx_re && !bus_rx_empty;
   assign rep_start = take && (st == P_REPLY) && !bus_rx_av;
   assign up_start  = take && (st == P_CMD) && !bus_rx_av && (hdr_op == OP_TXDATA)
                      && cfg_ok && (hdr_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= P_IDLE;
         cfg_ok       <= 1'b0;
         ip_sh        <= '0;
         ports_sh     <= '0;
         skip_left    <= '0;
         udp_len      <= '0;
         udp_dst_ip   <= '0;
         udp_dst_port <= '0;
         udp_src_port <= '0;
      end else begin
         case (st)
            P_IDLE: if (take && bus_rx_av) st <= P_CMD;
            P_CMD: if (take && !bus_rx_av) begin
               if (hdr_op == OP_TXCFG) begin
                  st <= P_IP;
               end else if (hdr_op == OP_TXDATA && hdr_len != '0) begin
                  if (cfg_ok) begin
                     udp_len <= hdr_len;
                     st      <= P_PAY;
                  end else begin
                     skip_left <= hdr_words;
                     st        <= P_SKIP;
                  end
               end else begin
                  st <= P_IDLE;
               end
            end
            P_IP: if (take) begin
               if (bus_rx_av) st <= P_CMD;
               else begin
                  ip_sh <= bus_rx_data;
                  st    <= P_PORTS;
               end
            end
            P_PORTS: if (take) begin
               if (bus_rx_av) st <= P_CMD;
               else begin
                  ports_sh <= bus_rx_data;
                  st       <= P_REPLY;
               end
            end
            P_REPLY: if (take) begin
               if (bus_rx_av) st <= P_CMD;
               else begin
                  udp_dst_ip   <= ip_sh;
                  udp_dst_port <= ports_sh[DATA_W-1:HALF_W];
                  udp_src_port <= ports_sh[HALF_W-1:0];
                  cfg_ok       <= 1'b1;
                  st           <= P_ACK;
               end
            end
            P_ACK: if (!rep_busy) st <= P_IDLE;
            P_PAY: if (up_done) st <= P_IDLE;
            P_SKIP: if (take) begin
               if (bus_rx_av) st <= P_CMD;
               else begin
                  skip_left <= skip_left - LEN_W'(1);
                  if (skip_left == LEN_W'(1)) st <= P_IDLE;
               end
            end
            default: st <= P_IDLE;
         endcase
      end
   end

   b2u_reply #(
      .DATA_W   (DATA_W),
      .ACK_CODE (ACK_CODE)
   ) i_reply (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rep_start),
      .addr  (bus_rx_data),
      .full  (bus_tx_full),
      .we    (bus_tx_we),
      .av    (bus_tx_av),
      .data  (bus_tx_data),
      .busy  (rep_busy)
   );

   b2u_unpack #(
      .DATA_W (DATA_W),
      .HALF_W (HALF_W),
      .CNT_W  (LEN_W)
   ) i_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (up_start),
      .total   (hdr_halves),
      .load    (take && st == P_PAY),
      .word_in (bus_rx_data),
      .re      (udp_re),
      .need    (up_need),
      .valid   (udp_valid),
      .data    (udp_data),
      .new_tx  (udp_new_tx),
      .done    (up_done)
   );

   // R10: no bus read while the reply is outstanding
   a_r10_no_read_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
      rep_busy |-> !bus_rx_re);

   // R9: discarding a payload never starts a transmit
   a_r9_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      st == P_SKIP |-> !udp_new_tx);

   // R5: addressing stays fixed while a transmit is open
   a_r5_len_steady: assert property (@(posedge clk) disable iff (!rst_n)
      udp_new_tx && $past(udp_new_tx) |-> $stable(udp_len) && $stable(udp_dst_ip));

endmodule

// File: tb/test_bus2udp_tx_bridge.sv
`timescale 1ns/1ps
module test_bus2udp_tx_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] bus_rx_data;
   logic        bus_rx_av, bus_rx_empty, bus_rx_re;
   logic [31:0] bus_tx_data;
   logic        bus_tx_av, bus_tx_we;
   logic        bus_tx_full = 1'b0;
   logic        udp_new_tx;
   logic [10:0] udp_len;
   logic [31:0] udp_dst_ip;
   logic [15:0] udp_dst_port, udp_src_port, udp_data;
   logic        udp_valid;
   logic        udp_re = 1'b0;

   bus2udp_tx_bridge i_bus2udp_tx_bridge (
      .clk(clk), .rst_n(rst_n),
      .bus_rx_data(bus_rx_data), .bus_rx_av(bus_rx_av),
      .bus_rx_empty(bus_rx_empty), .bus_rx_re(bus_rx_re),
      .bus_tx_data(bus_tx_data), .bus_tx_av(bus_tx_av),
      .bus_tx_we(bus_tx_we), .bus_tx_full(bus_tx_full),
      .udp_new_tx(udp_new_tx), .udp_len(udp_len), .udp_dst_ip(udp_dst_ip),
      .udp_dst_port(udp_dst_port), .udp_src_port(udp_src_port),
      .udp_data(udp_data), .udp_valid(udp_valid), .udp_re(udp_re)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // bus word source
   logic [32:0] src_mem [64];
   int src_cnt = 0;
   int src_idx = 0;
   assign bus_rx_empty = (src_idx >= src_cnt);
   assign {bus_rx_av, bus_rx_data} = src_mem[src_idx[5:0]];
   always @(posedge clk) if (bus_rx_re && !bus_rx_empty) src_idx <= src_idx + 1;

   // UDP consumer
   int re_mode = 0;
   int ph = 0;
   always @(negedge clk) begin
      ph <= ph + 1;
      case (re_mode)
         0:       udp_re <= 1'b1;
         1:       udp_re <= ph[0];
         2:       udp_re <= 1'b0;
         default: udp_re <= (ph % 3 == 0);
      endcase
   end

   logic [15:0] cap_d  [64];
   logic        cap_nt [64];
   logic [10:0] cap_ln [64];
   int cap_n = 0;
   always @(posedge clk) if (udp_valid && udp_re) begin
      cap_d[cap_n[5:0]]  <= udp_data;
      cap_nt[cap_n[5:0]] <= udp_new_tx;
      cap_ln[cap_n[5:0]] <= udp_len;
      cap_n <= cap_n + 1;
   end

   // reply sink
   logic [32:0] rep [8];
   int rep_n = 0;
   always @(posedge clk) if (bus_tx_we && !bus_tx_full) begin
      rep[rep_n[2:0]] <= {bus_tx_av, bus_tx_data};
      rep_n <= rep_n + 1;
   end

   // transmit vectors: [31:27] expected halves, [26:16] length, [9:8] re mode, [7:0] seed
   localparam logic [31:0] VEC [8] = '{
      {5'd1,  11'd1,  6'd0, 2'd0, 8'h11},
      {5'd1,  11'd2,  6'd0, 2'd1, 8'h22},
      {5'd2,  11'd3,  6'd0, 2'd1, 8'h33},
      {5'd2,  11'd4,  6'd0, 2'd0, 8'h44},
      {5'd3,  11'd5,  6'd0, 2'd3, 8'h55},
      {5'd4,  11'd8,  6'd0, 2'd1, 8'h66},
      {5'd7,  11'd13, 6'd0, 2'd0, 8'h77},
      {5'd11, 11'd21, 6'd0, 2'd3, 8'h88}
   };

   localparam logic [31:0] REPLY_ADDR = 32'h0700_0040;
   localparam logic [31:0] DST_IP     = 32'hC0A8_0A07;
   localparam logic [31:0] PORT_WORD  = 32'h1F90_0035;

   function automatic logic [31:0] pay_word(int n, logic [7:0] seed);
      return {8'(4*n+3), 8'(4*n+2), 8'(4*n+1), 8'(4*n)} ^ {4{seed}};
   endfunction

   function automatic logic [31:0] hdr(logic [3:0] op, logic [10:0] len);
      return {op, len, 17'd0};
   endfunction

   task automatic push(logic av, logic [31:0] d);
      src_mem[src_cnt[5:0]] = {av, d};
      src_cnt = src_cnt + 1;
   endtask

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 new_tx", 64'(udp_new_tx), 64'd0);
      chk("R1 valid",  64'(udp_valid),  64'd0);
      chk("R1 we",     64'(bus_tx_we),  64'd0);
      chk("R1 rx_re",  64'(bus_rx_re),  64'd1);

      // R9 data header before any configuration
      push(1'b1, 32'h0100_0000);
      push(1'b0, hdr(4'h1, 11'd9));
      for (int w = 0; w < 3; w++) push(1'b0, pay_word(w, 8'hF0));
      for (int t = 0; t < 50 && src_idx < src_cnt; t++) wait_cyc(1);
      wait_cyc(5);
      chk("R9 words drained", 64'(src_idx), 64'(src_cnt));
      chk("R9 no halves",     64'(cap_n),   64'd0);
      chk("R9 no new_tx",     64'(udp_new_tx), 64'd0);
      chk("R9 no reply",      64'(rep_n),   64'd0);

      // R2/R3/R4/R10 configuration with the reply port held full
      bus_tx_full = 1'b1;
      push(1'b1, 32'h0100_0000);
      push(1'b0, 32'h0000_1234);
      push(1'b0, DST_IP);
      push(1'b0, PORT_WORD);
      push(1'b0, REPLY_ADDR);
      push(1'b1, 32'h0100_0000);
      wait_cyc(20);
      chk("R4 we held",      64'(bus_tx_we),   64'd1);
      chk("R4 av held",      64'(bus_tx_av),   64'd1);
      chk("R4 data held",    64'(bus_tx_data), 64'(REPLY_ADDR));
      chk("R4 nothing sent", 64'(rep_n),       64'd0);
      chk("R10 no read during reply", 64'(src_idx), 64'(src_cnt - 1));
      bus_tx_full = 1'b0;
      wait_cyc(6);
      chk("R3 reply count", 64'(rep_n),  64'd2);
      chk("R3 address word", 64'(rep[0]), 64'({1'b1, REPLY_ADDR}));
      chk("R3 ack word",     64'(rep[1]), 64'({1'b0, 32'h5800_0000}));
      chk("R2 dst ip",   64'(udp_dst_ip),   64'(DST_IP));
      chk("R2 dst port", 64'(udp_dst_port), 64'(PORT_WORD[31:16]));
      chk("R2 src port", 64'(udp_src_port), 64'(PORT_WORD[15:0]));
      chk("R10 queued word read", 64'(src_idx), 64'(src_cnt));

      // table of transmits: R5 R6 R7 R8
      for (int i = 0; i < 8; i++) begin
         logic [31:0] v;
         int halves, len;
         v = VEC[i];
         halves = int'(v[31:27]);
         len = int'(v[26:16]);
         base = cap_n;
         re_mode = int'(v[9:8]);
         push(1'b1, 32'h0100_0000);
         push(1'b0, hdr(4'h1, 11'(len)));
         for (int w = 0; w < (len + 3) / 4; w++) push(1'b0, pay_word(w, v[7:0]));
         for (int t = 0; t < 400 && cap_n - base < halves; t++) wait_cyc(1);
         wait_cyc(4);
         chk("R6 half count", 64'(cap_n - base), 64'(halves));
         for (int k = 0; k < halves; k++) begin
            logic [31:0] w;
            w = pay_word(k / 2, v[7:0]);
            chk("R6 half order", 64'(cap_d[(base + k) % 64]),
                64'((k % 2 == 1) ? w[31:16] : w[15:0]));
         end
         chk("R5 new_tx with first half", 64'(cap_nt[base % 64]), 64'd1);
         chk("R5 length", 64'(cap_ln[base % 64]), 64'(len));
         chk("R8 new_tx low", 64'(udp_new_tx), 64'd0);
         chk("R8 valid low",  64'(udp_valid),  64'd0);
         re_mode = 0;
         wait_cyc(2);
      end

      // R7 consumer stalls, then releases
      re_mode = 2;
      wait_cyc(2);
      base = cap_n;
      push(1'b1, 32'h0100_0000);
      push(1'b0, hdr(4'h1, 11'd6));
      push(1'b0, pay_word(0, 8'h5A));
      push(1'b0, pay_word(1, 8'h5A));
      wait_cyc(12);
      chk("R7 valid held",  64'(udp_valid), 64'd1);
      chk("R7 data held",   64'(udp_data),  64'(pay_word(0, 8'h5A) & 32'hFFFF));
      chk("R7 no transfer", 64'(cap_n - base), 64'd0);
      chk("R5 new_tx open", 64'(udp_new_tx), 64'd1);
      chk("R5 len shown",   64'(udp_len),    64'd6);
      re_mode = 0;
      wait_cyc(12);
      chk("R6 three halves", 64'(cap_n - base), 64'd3);
      chk("R6 third half",   64'(cap_d[(base + 2) % 64]), 64'(pay_word(1, 8'h5A) & 32'hFFFF));
      chk("R8 closed",       64'(udp_new_tx), 64'd0);

      finish_run();
   end

endmodule